// File: doc/BRIEF.md
# Three-Register Host Message Port Responder

This block is the managed-controller side of a polled, byte-wide host message port. A host sees three byte registers: a data register, a control register that reads back as a status register, and a flags register. The host places a byte in the data register and a control code in the control register. It then writes the flags register with the busy bit set. After a fixed, parameterised delay the responder carries out the control code, updates status and data, and clears busy.

The request bytes that the host writes are collected in a request buffer. When a request completes, its length and contents are presented on a side read port. A response message is loaded through a separate byte-stream port. The host then reads it one byte per control step. Errors are reported in the data register at the end of the write phase and at the end of the read phase.

Top module: `msgport_responder`

## Requirements
- R1: After reset, status reads 0xC0, data reads 0x00 and flags read 0x00.
- R2: A host write of the flags register (address 2) with bit 0 high, while not busy, sets busy (flags bit 0). Busy stays set for exactly BUSY_LAT cycles and is then cleared by the responder, and the step's results are readable from that point.
- R3: While busy is set, every host write (data, control and flags) is ignored. The step in progress uses the control code and data byte latched before busy was raised.
- R4: Control codes have the form 0x40 | op. A successful step reports status 0xC0 | op. Get-status (0x40) in the ready phase answers 0xC0 and leaves the data register unchanged.
- R5: Write-start (0x41) is accepted in the ready phase, and write-next (0x42) and write-end (0x43) in the write phase. Each stores the data byte in order, and TX-ready (flags 0x40) is set while writing. Write-end of a request of at most REQ_DEPTH bytes gives status 0xC3 and data 0x00, and presents the request with its length on the request port.
- R6: A request longer than REQ_DEPTH bytes gives status 0xC3 and data 0x05 (buffer full) at write-end. It returns to the ready phase and presents no request. A request of exactly REQ_DEPTH bytes succeeds.
- R7: A response loaded byte by byte with a last marker sets message-available (flags 0x04). After a successful write-end, RX-ready (flags 0x80) is also set.
- R8: Read-start (0x44) puts byte 0 in the data register with status 0xC4. Each read-next (0x45) puts the next byte there with status 0xC5, or 0xC6 when it is the last byte. RX-ready stays set while unread bytes remain, and TX-ready and RX-ready are never set together.
- R9: Read-end (0x46) after the last byte gives status 0xC0 and data 0x00, and discards the response, clearing message-available.
- R10: Read-end before the last byte has been read gives status 0xC0 and data 0x01 (aborted), and also discards the response.
- R11: A control code that is out of sequence for the current phase, or is not one of 0x40 to 0x46, gives status 0xC0 and data 0x02 (illegal control) and returns to the ready phase. This includes read-start with no response loaded.
- R12: Flags bits 5, 4, 3 and 1 always read 0, so flags never read 0xFF. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 2 | Host write address (0 data, 1 control, 2 flags) |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 2 | Host read address (0 data, 1 status, 2 flags) |
| host_rdata | output | 8 | Host read data, combinational on host_raddr |
| rsp_we | input | 1 | Response byte strobe |
| rsp_wbyte | input | 8 | Response byte |
| rsp_wlast | input | 1 | Marks the final response byte |
| req_valid | output | 1 | A complete request is held |
| req_len | output | $clog2(REQ_DEPTH+1) | Request length in bytes |
| req_raddr | input | $clog2(REQ_DEPTH) | Request byte index |
| req_rdata | output | 8 | Request byte at req_raddr |

## Verification
Every host step has one deadline. The flags write lands on a clock edge, busy reads 1 on each of the next BUSY_LAT falling edges, and the status, data and flags of that step are first due on the falling edge after that. The monitor counts exactly those falling edges for each queued expectation, checks busy on each of them, and only then reads the three registers. Response loading and request contents take effect on the edge after their strobe, so they are checked on the next falling edge with no busy wait.

// File: rtl/msgport_pkg.sv
package msgport_pkg;
  typedef enum logic [1:0] {PH_READY, PH_WRITE, PH_AWAIT, PH_READ} phase_e;

  localparam logic [3:0] OP_STATUS = 4'd0;
  localparam logic [3:0] OP_WSTART = 4'd1;
  localparam logic [3:0] OP_WNEXT  = 4'd2;
  localparam logic [3:0] OP_WEND   = 4'd3;
  localparam logic [3:0] OP_RSTART = 4'd4;
  localparam logic [3:0] OP_RNEXT  = 4'd5;
  localparam logic [3:0] OP_REND   = 4'd6;

  localparam logic [3:0] CTL_PREFIX = 4'h4;
  localparam logic [3:0] STS_PREFIX = 4'hC;

  localparam logic [7:0] ERR_NONE   = 8'h00;
  localparam logic [7:0] ERR_ABORT  = 8'h01;
  localparam logic [7:0] ERR_BADCTL = 8'h02;
  localparam logic [7:0] ERR_FULL   = 8'h05;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CTL  = 2'd1;
  localparam logic [1:0] ADR_FLG  = 2'd2;
endpackage

// File: rtl/msgport_busy.sv
module msgport_busy #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy,
  output logic fire
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fire   = busy_q && (cnt_q == '0);
    if (fire) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end else if (arm) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/msgport_reqbuf.sv
module msgport_reqbuf #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       first,
  input  logic                       push,
  input  logic [7:0]                 wbyte,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          wr_en;
  logic [IW-1:0] wr_idx;

  always_comb begin
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    wr_en  = 1'b0;
    wr_idx = cnt_q[IW-1:0];
    if (first) begin
      cnt_d  = CW'(1);
      ovf_d  = 1'b0;
      wr_en  = 1'b1;
      wr_idx = '0;
    end else if (push) begin
      if (cnt_q == CW'(DEPTH)) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        wr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign rd_data = mem[rd_idx];
  assign count   = cnt_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/msgport_rspbuf.sv
module msgport_rspbuf #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [7:0]                 load_byte,
  input  logic                       load_last,
  input  logic                       clear,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0] len,
  output logic                       ready
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] len_q, len_d;
  logic          rdy_q, rdy_d;
  logic          wr_en;

  always_comb begin
    len_d = len_q;
    rdy_d = rdy_q;
    wr_en = 1'b0;
    if (clear) begin
      len_d = '0;
      rdy_d = 1'b0;
    end else if (load_en && !rdy_q) begin
      if (len_q < CW'(DEPTH)) begin
        wr_en = 1'b1;
        len_d = len_q + 1'b1;
      end
      if (load_last) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[len_q[IW-1:0]] <= load_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      len_q <= len_d;
      rdy_q <= rdy_d;
    end
  end

  assign rd_data = mem[rd_idx];
  assign len     = len_q;
  assign ready   = rdy_q;
endmodule

// File: rtl/msgport_seq.sv
module msgport_seq
  import msgport_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int RSP_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           exec,
  input  logic [7:0]                     ctl,
  input  logic [$clog2(REQ_DEPTH+1)-1:0] req_count,
  input  logic                           req_ovf,
  input  logic                           rsp_ready,
  input  logic [$clog2(RSP_DEPTH+1)-1:0] rsp_len,
  input  logic [7:0]                     rsp_byte,
  output logic [$clog2(RSP_DEPTH)-1:0]   rsp_idx,
  output logic                           rsp_clear,
  output logic                           req_first,
  output logic                           req_push,
  output logic                           req_valid,
  output logic [7:0]                     status,
  output logic [7:0]                     data,
  output logic                           tx_rdy,
  output logic                           rx_rdy
);
  localparam int QW = $clog2(REQ_DEPTH + 1);
  localparam int PW = $clog2(RSP_DEPTH + 1);
  localparam int IW = $clog2(RSP_DEPTH);

  phase_e        ph_q, ph_d;
  logic [7:0]    st_q, st_d;
  logic [7:0]    dat_q, dat_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          rqv_q, rqv_d;
  logic          bad;
  logic [3:0]    op;

  assign op = ctl[3:0];

  always_comb begin
    ph_d      = ph_q;
    st_d      = st_q;
    dat_d     = dat_q;
    pos_d     = pos_q;
    rqv_d     = rqv_q;
    req_first = 1'b0;
    req_push  = 1'b0;
    rsp_clear = 1'b0;
    bad       = 1'b0;
    if (exec) begin
      bad = 1'b1;
      if (ctl[7:4] == CTL_PREFIX) begin
        case (op)
          OP_STATUS: if (ph_q == PH_READY) begin
            bad  = 1'b0;
            st_d = {STS_PREFIX, op};
          end
          OP_WSTART: if (ph_q == PH_READY) begin
            bad       = 1'b0;
            st_d      = {STS_PREFIX, op};
            ph_d      = PH_WRITE;
            req_first = 1'b1;
            rqv_d     = 1'b0;
          end
          OP_WNEXT: if (ph_q == PH_WRITE) begin
            bad      = 1'b0;
            st_d     = {STS_PREFIX, op};
            req_push = 1'b1;
          end
          OP_WEND: if (ph_q == PH_WRITE) begin
            bad      = 1'b0;
            st_d     = {STS_PREFIX, op};
            req_push = 1'b1;
            pos_d    = '0;
            if (req_ovf || (req_count == QW'(REQ_DEPTH))) begin
              dat_d = ERR_FULL;
              ph_d  = PH_READY;
            end else begin
              dat_d = ERR_NONE;
              ph_d  = PH_AWAIT;
              rqv_d = 1'b1;
            end
          end
          OP_RSTART: if (ph_q == PH_AWAIT && rsp_ready && rsp_len != '0) begin
            bad   = 1'b0;
            st_d  = {STS_PREFIX, op};
            dat_d = rsp_byte;
            pos_d = PW'(1);
            ph_d  = PH_READ;
          end
          OP_RNEXT: if (ph_q == PH_READ && pos_q < rsp_len) begin
            bad   = 1'b0;
            dat_d = rsp_byte;
            pos_d = pos_q + 1'b1;
            st_d  = (pos_q + 1'b1 == rsp_len) ? {STS_PREFIX, OP_REND}
                                             : {STS_PREFIX, OP_RNEXT};
          end
          OP_REND: if (ph_q == PH_READ) begin
            bad       = 1'b0;
            st_d      = {STS_PREFIX, OP_STATUS};
            dat_d     = (pos_q == rsp_len) ? ERR_NONE : ERR_ABORT;
            ph_d      = PH_READY;
            rsp_clear = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      if (bad) begin
        st_d  = {STS_PREFIX, OP_STATUS};
        dat_d = ERR_BADCTL;
        ph_d  = PH_READY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_READY;
      st_q  <= {STS_PREFIX, OP_STATUS};
      dat_q <= ERR_NONE;
      pos_q <= '0;
      rqv_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      st_q  <= st_d;
      dat_q <= dat_d;
      pos_q <= pos_d;
      rqv_q <= rqv_d;
    end
  end

  assign rsp_idx   = pos_q[IW-1:0];
  assign req_valid = rqv_q;
  assign status    = st_q;
  assign data      = dat_q;
  assign tx_rdy    = (ph_q == PH_WRITE);
  assign rx_rdy    = ((ph_q == PH_AWAIT) && rsp_ready) ||
                     ((ph_q == PH_READ) && (pos_q < rsp_len));
endmodule

// File: rtl/msgport_responder.sv
module msgport_responder
  import msgport_pkg::*;
#(
  parameter int BUSY_LAT  = 3,
  parameter int REQ_DEPTH = 8,
  parameter int RSP_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_we,
  input  logic [1:0]                     host_waddr,
  input  logic [7:0]                     host_wdata,
  input  logic [1:0]                     host_raddr,
  output logic [7:0]                     host_rdata,
  input  logic                           rsp_we,
  input  logic [7:0]                     rsp_wbyte,
  input  logic                           rsp_wlast,
  output logic                           req_valid,
  output logic [$clog2(REQ_DEPTH+1)-1:0] req_len,
  input  logic [$clog2(REQ_DEPTH)-1:0]   req_raddr,
  output logic [7:0]                     req_rdata
);
  localparam int QW = $clog2(REQ_DEPTH + 1);
  localparam int PW = $clog2(RSP_DEPTH + 1);
  localparam int IW = $clog2(RSP_DEPTH);

  logic          busy, fire, arm, wr_ok;
  logic [7:0]    ctl_q, hdat_q;
  logic [7:0]    status_q, data_q, flags_w;
  logic          tx_rdy, rx_rdy;
  logic          req_first, req_push, req_ovf;
  logic [QW-1:0] req_count;
  logic          rsp_ready, rsp_clear;
  logic [PW-1:0] rsp_len;
  logic [IW-1:0] rsp_idx;
  logic [7:0]    rsp_byte;

  assign wr_ok = host_we && !busy;
  assign arm   = wr_ok && (host_waddr == ADR_FLG) && host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      hdat_q <= '0;
    end else begin
      if (wr_ok && host_waddr == ADR_CTL)  ctl_q  <= host_wdata;
      if (wr_ok && host_waddr == ADR_DATA) hdat_q <= host_wdata;
    end
  end

  msgport_busy #(.LAT(BUSY_LAT)) u_busy (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .fire(fire)
  );

  msgport_reqbuf #(.DEPTH(REQ_DEPTH)) u_req (
    .clk(clk), .rst_n(rst_n), .first(req_first), .push(req_push),
    .wbyte(hdat_q), .rd_idx(req_raddr), .rd_data(req_rdata),
    .count(req_count), .ovf(req_ovf)
  );

  msgport_rspbuf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load_en(rsp_we), .load_byte(rsp_wbyte),
    .load_last(rsp_wlast), .clear(rsp_clear), .rd_idx(rsp_idx),
    .rd_data(rsp_byte), .len(rsp_len), .ready(rsp_ready)
  );

  msgport_seq #(.REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .exec(fire), .ctl(ctl_q),
    .req_count(req_count), .req_ovf(req_ovf), .rsp_ready(rsp_ready),
    .rsp_len(rsp_len), .rsp_byte(rsp_byte), .rsp_idx(rsp_idx),
    .rsp_clear(rsp_clear), .req_first(req_first), .req_push(req_push),
    .req_valid(req_valid), .status(status_q), .data(data_q),
    .tx_rdy(tx_rdy), .rx_rdy(rx_rdy)
  );

  assign req_len = req_count;
  assign flags_w = {rx_rdy, tx_rdy, 3'b000, rsp_ready, 1'b0, busy};

  always_comb begin
    case (host_raddr)
      ADR_DATA: host_rdata = data_q;
      ADR_CTL:  host_rdata = status_q;
      ADR_FLG:  host_rdata = flags_w;
      default:  host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/msgport_responder_chk.sv
module msgport_responder_chk #(
  parameter int LAT = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic [1:0] host_waddr,
  input logic [7:0] host_wdata,
  input logic       busy,
  input logic [7:0] flags,
  input logic [7:0] status,
  input logic       msg
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  AST_BUSY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_waddr == 2'd2 && host_wdata[0] && !busy |=> busy); // R2

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == LAT); // R2

  AST_STATUS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(status)); // R3

  AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[7] && flags[6])); // R8

  AST_MSG_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg) |-> status == 8'hC0); // R9

  AST_FLAGS_NOT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    flags != 8'hFF); // R12
endmodule

bind msgport_responder msgport_responder_chk #(.LAT(BUSY_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
  .host_wdata(host_wdata), .busy(busy), .flags(flags_w),
  .status(status_q), .msg(rsp_ready)
);

// File: tb/msgport_responder_test.sv
`timescale 1ns/1ps
module msgport_responder_test;
  localparam int LAT = 3;
  localparam int RQD = 8;
  localparam int RSD = 16;

  logic       clk, rst_n, host_we, rsp_we, rsp_wlast, req_valid;
  logic [1:0] host_waddr, host_raddr;
  logic [7:0] host_wdata, host_rdata, rsp_wbyte, req_rdata;
  logic [3:0] req_len;
  logic [2:0] req_raddr;

  msgport_responder #(.BUSY_LAT(LAT), .REQ_DEPTH(RQD), .RSP_DEPTH(RSD)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .rsp_we(rsp_we), .rsp_wbyte(rsp_wbyte), .rsp_wlast(rsp_wlast),
    .req_valid(req_valid), .req_len(req_len), .req_raddr(req_raddr),
    .req_rdata(req_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // scoreboard: kind 0 = host step, 1 = register peek, 2 = request check
  int         q_kind[$];
  string      q_tag[$];
  logic [7:0] q_st[$];
  logic [7:0] q_dat[$];
  logic [7:0] q_flg[$];
  logic [7:0] exp_req[RQD];
  int         issued;
  int         retired;
  int         n_chk;
  int         n_bad;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    host_raddr = a;
    #0.3;
    v = host_rdata;
  endtask

  // monitor
  initial begin
    int k;
    string t;
    logic [7:0] es, ed, ef, v;
    n_chk = 0; n_bad = 0; retired = 0;
    host_raddr = 2'd0; req_raddr = '0;
    forever begin
      wait (q_kind.size() > 0);
      k = q_kind.pop_front(); t = q_tag.pop_front();
      es = q_st.pop_front(); ed = q_dat.pop_front(); ef = q_flg.pop_front();
      if (k == 0) begin
        for (int i = 0; i < LAT; i++) begin
          @(negedge clk);
          rd(2'd2, v);
          chk({t, " R2 busy held"}, {7'd0, v[0]}, 8'h01);
        end
        @(negedge clk);
        rd(2'd2, v); chk({t, " flags"}, v, ef);
        rd(2'd1, v); chk({t, " status"}, v, es);
        rd(2'd0, v); chk({t, " data"}, v, ed);
      end else if (k == 1) begin
        @(negedge clk);
        rd(2'd2, v); chk({t, " flags"}, v, ef);
        rd(2'd1, v); chk({t, " status"}, v, es);
        rd(2'd0, v); chk({t, " data"}, v, ed);
        rd(2'd3, v); chk({t, " R12 addr3"}, v, 8'h00);
      end else begin
        @(negedge clk);
        chk({t, " valid"}, {7'd0, req_valid}, es);
        if (es[0]) begin
          chk({t, " len"}, {4'd0, req_len}, ed);
          for (int i = 0; i < int'(ed); i++) begin
            req_raddr = 3'(i);
            #0.1;
            chk({t, " byte"}, req_rdata, exp_req[i]);
          end
        end
      end
      retired++;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_waddr = a; host_wdata = d; host_we = 1'b1;
    @(posedge clk);
    #0.5;
    host_we = 1'b0;
  endtask

  task automatic push(input int k, input string t, input logic [7:0] s,
                      input logic [7:0] d, input logic [7:0] f);
    q_tag.push_back(t); q_st.push_back(s); q_dat.push_back(d); q_flg.push_back(f);
    q_kind.push_back(k);
    issued++;
  endtask

  task automatic step(input string t, input logic [7:0] c, input logic [7:0] d,
                      input logic [7:0] es, input logic [7:0] ed, input logic [7:0] ef);
    bus_wr(2'd0, d);
    bus_wr(2'd1, c);
    bus_wr(2'd2, 8'h01);
    push(0, t, es, ed, ef);
    wait (retired == issued);
  endtask

  task automatic step_intrude(input string t, input logic [7:0] c,
                              input logic [7:0] es, input logic [7:0] ed,
                              input logic [7:0] ef);
    bus_wr(2'd1, c);
    bus_wr(2'd2, 8'h01);
    push(0, t, es, ed, ef);
    bus_wr(2'd1, 8'h41);
    bus_wr(2'd2, 8'h01);
    wait (retired == issued);
  endtask

  task automatic peek(input string t, input logic [7:0] es, input logic [7:0] ed,
                      input logic [7:0] ef);
    push(1, t, es, ed, ef);
    wait (retired == issued);
  endtask

  task automatic req_check(input string t, input logic v, input logic [7:0] n);
    push(2, t, {7'd0, v}, n, 8'h00);
    wait (retired == issued);
  endtask

  task automatic rsp_put(input logic [7:0] b, input logic last);
    @(negedge clk);
    rsp_we = 1'b1; rsp_wbyte = b; rsp_wlast = last;
    @(posedge clk);
    #0.5;
    rsp_we = 1'b0; rsp_wlast = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  // driver
  initial begin
    issued = 0;
    rst_n = 1'b0; host_we = 1'b0; host_waddr = '0; host_wdata = '0;
    rsp_we = 1'b0; rsp_wbyte = '0; rsp_wlast = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    peek("R1 reset", 8'hC0, 8'h00, 8'h00);
    step("R4 get-status", 8'h40, 8'h00, 8'hC0, 8'h00, 8'h00);
    step_intrude("R3 writes ignored while busy", 8'h40, 8'hC0, 8'h00, 8'h00);

    step("R5 write-start", 8'h41, 8'h18, 8'hC1, 8'h00, 8'h40);
    step("R5 write-next", 8'h42, 8'h01, 8'hC2, 8'h00, 8'h40);
    step("R5 write-end", 8'h43, 8'h22, 8'hC3, 8'h00, 8'h00);
    exp_req[0] = 8'h18; exp_req[1] = 8'h01; exp_req[2] = 8'h22;
    req_check("R5 request", 1'b1, 8'd3);

    rsp_put(8'h1C, 1'b0); rsp_put(8'h01, 1'b0); rsp_put(8'h00, 1'b0); rsp_put(8'hAB, 1'b1);
    peek("R7 response loaded", 8'hC3, 8'h00, 8'h84);

    step("R8 read-start", 8'h44, 8'h00, 8'hC4, 8'h1C, 8'h84);
    step("R8 read-next 1", 8'h45, 8'h00, 8'hC5, 8'h01, 8'h84);
    step("R8 read-next 2", 8'h45, 8'h00, 8'hC5, 8'h00, 8'h84);
    step("R8 read-next last", 8'h45, 8'h00, 8'hC6, 8'hAB, 8'h04);
    step("R9 read-end", 8'h46, 8'h00, 8'hC0, 8'h00, 8'h00);

    step("R11 read-next in ready", 8'h45, 8'h00, 8'hC0, 8'h02, 8'h00);
    step("R11 wrong stream bits", 8'h61, 8'h00, 8'hC0, 8'h02, 8'h00);
    step("R11 unknown op", 8'h47, 8'h00, 8'hC0, 8'h02, 8'h00);

    step("R6 overflow start", 8'h41, 8'h00, 8'hC1, 8'h02, 8'h40);
    for (int i = 0; i < RQD; i++)
      step("R6 overflow next", 8'h42, 8'(i), 8'hC2, 8'h02, 8'h40);
    step("R6 overflow end", 8'h43, 8'h99, 8'hC3, 8'h05, 8'h00);
    step("R6 back to ready", 8'h40, 8'h00, 8'hC0, 8'h05, 8'h00);
    req_check("R6 no request", 1'b0, 8'd0);

    for (int i = 0; i < RQD; i++) exp_req[i] = 8'hA0 + 8'(i);
    step("R6 exact start", 8'h41, exp_req[0], 8'hC1, 8'h05, 8'h40);
    for (int i = 1; i < RQD - 1; i++)
      step("R6 exact next", 8'h42, exp_req[i], 8'hC2, 8'h05, 8'h40);
    step("R6 exact end", 8'h43, exp_req[RQD-1], 8'hC3, 8'h00, 8'h00);
    req_check("R6 exact request", 1'b1, 8'(RQD));

    step("R11 read-start without response", 8'h44, 8'h00, 8'hC0, 8'h02, 8'h00);

    step("R10 start", 8'h41, 8'h07, 8'hC1, 8'h02, 8'h40);
    step("R10 end", 8'h43, 8'h08, 8'hC3, 8'h00, 8'h00);
    rsp_put(8'h11, 1'b0); rsp_put(8'h22, 1'b0); rsp_put(8'h33, 1'b1);
    step("R10 read-start", 8'h44, 8'h00, 8'hC4, 8'h11, 8'h84);
    step("R10 early read-end", 8'h46, 8'h00, 8'hC0, 8'h01, 8'h00);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule